// File: doc/BRIEF.md
# CAN Fault Confinement State and Interrupt Controller

This block watches the transmit and receive error counters that a CAN protocol engine reports and works out the node's fault confinement state: error active, warning, error passive or bus-off. It raises an event the first time each state threshold is crossed. It also raises an event when the protocol engine reports bus-off. It latches the cause of each bus error and keeps a small global interrupt flag word. Software clears bits in that word by writing ones.

Each flag has its own mask bit. The flags drive two interrupt lines. Line enables come from a global mask word, and one control bit sends the system flags (warning, passive, bus-off) to line 1 instead of line 0. The mailbox summary flag always goes to line 0. The rules for incrementing the counters and the recovery from bus-off are handled elsewhere. This block only sees the counter values and the bus-off indication.

Top module: `can_fault_irq_ctrl`

## Requirements
- R1: After reset, `state_o` is 0, `status_o` and `flag_o` are all zero, and both interrupt lines are low.
- R2: `state_o` uses the encoding 0 active, 1 warning, 2 passive, 3 bus-off. It shows passive when either counter is 128 or more, warning when either counter is 96 or more and neither is 128 or more, and active otherwise. Bus-off overrides all three. The state is registered, so it reflects the inputs sampled at the previous clock edge.
- R3: When either counter first reaches 96 or more, flag bit 8 and status bit 16 are set. While the condition still holds they are not set again, so clearing them makes them stay clear.
- R4: When either counter first reaches 128 or more, flag bit 9 and status bit 17 are set. A single jump from below 96 to 128 or more sets bits 8 and 9 together.
- R5: A rising `bus_off_i` sets flag bit 10 and status bit 18 and moves the state to bus-off, whatever the counter values are.
- R6: A pulse on `bus_err_i` latches its cause into status. Bit 5 form maps to status bit 24, bit 4 bit-error to 23, bit 3 stuck-dominant to 22, bit 2 CRC to 21, bit 1 stuff to 20, and bit 0 ack to 19. Each latched bit stays set until it is cleared.
- R7: A pulse on `mbox_evt_i` sets flag bit 15.
- R8: A cycle with `status_clr_i` or `flag_clr_i` high clears the bits of that word where `clr_data_i` holds a one. A set and a clear of the same bit in the same cycle leave the bit set.
- R9: Flags latch whatever their mask bits are. Global mask bits 8, 9, 10 and 15 enable the matching flags. `irq0_o` is high when mask bit 0 is set and one of these holds: the enabled mailbox flag is set, or an enabled system flag is set while mask bit 2 is clear.
- R10: `irq1_o` is high when mask bits 1 and 2 are set and an enabled system flag is set. The mailbox flag never drives line 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tec_i | input | CNT_W | Transmit error counter |
| rec_i | input | CNT_W | Receive error counter |
| bus_off_i | input | 1 | Bus-off indication from protocol engine |
| bus_err_i | input | 6 | Bus error cause pulses (form, bit, stuck, CRC, stuff, ack) |
| mbox_evt_i | input | 1 | Mailbox summary event pulse |
| gim_i | input | 32 | Global mask: line enables, routing bit, per-flag enables |
| status_clr_i | input | 1 | Write-one-to-clear strobe for status |
| flag_clr_i | input | 1 | Write-one-to-clear strobe for flags |
| clr_data_i | input | 32 | Clear data, ones select bits |
| status_o | output | 32 | Error and status word |
| flag_o | output | 32 | Global interrupt flag word |
| state_o | output | 2 | Fault confinement state |
| irq0_o | output | 1 | Interrupt line 0 |
| irq1_o | output | 1 | Interrupt line 1 |

## Verification
Counter values, bus-off, cause pulses, mailbox events and clear strobes all land in registers at a single clock edge. The state, status bits and flag bits are therefore due one edge after the stimulus. The interrupt lines are combinational from the flags and the mask, so they change in the same cycle as a flag or as soon as the mask changes. The bench drives every input on a falling edge, lets one rising edge pass, and samples on the following falling edge. Threshold checks step the counters one value at a time across each limit. Clears are repeated while a condition still holds, to show that the flag set by an edge does not come back.

// File: rtl/can_fault_pkg.sv
package can_fault_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_WARN    = 2'd1,
    ST_PASSIVE = 2'd2,
    ST_BUSOFF  = 2'd3
  } fault_state_e;

  localparam int REG_W     = 32;
  localparam int NCAUSE    = 6;
  // global flag / mask positions
  localparam int FL_WARN   = 8;
  localparam int FL_PASS   = 9;
  localparam int FL_BOFF   = 10;
  localparam int FL_MBOX   = 15;
  localparam int GM_LINE0  = 0;
  localparam int GM_LINE1  = 1;
  localparam int GM_SYS_L1 = 2;
  // status positions
  localparam int SB_WARN   = 16;
  localparam int SB_PASS   = 17;
  localparam int SB_BOFF   = 18;
  localparam int SB_CAUSE  = 19;

  localparam logic [REG_W-1:0] SYS_FLAGS   = (32'd1 << FL_WARN) | (32'd1 << FL_PASS) | (32'd1 << FL_BOFF);
  localparam logic [REG_W-1:0] MBOX_FLAGS  = 32'd1 << FL_MBOX;
  localparam logic [REG_W-1:0] FLAG_USED   = SYS_FLAGS | MBOX_FLAGS;
  localparam logic [REG_W-1:0] STATUS_USED = ((32'd1 << (SB_CAUSE + NCAUSE)) - 1) & ~((32'd1 << SB_WARN) - 1);
endpackage

// File: rtl/can_fault_eval.sv
module can_fault_eval
  import can_fault_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] tec_i,
  input  logic [CNT_W-1:0] rec_i,
  input  logic             bus_off_i,
  output logic [1:0]       state_o,
  output logic             warn_rise_o,
  output logic             pass_rise_o,
  output logic             boff_rise_o
);
  localparam logic [CNT_W-1:0] WARN_V = CNT_W'(WARN_LIM);
  localparam logic [CNT_W-1:0] PASS_V = CNT_W'(PASS_LIM);

  logic ge_warn, ge_pass;
  logic warn_q, pass_q, boff_q;
  fault_state_e st;

  assign ge_warn = (tec_i >= WARN_V) || (rec_i >= WARN_V);
  assign ge_pass = (tec_i >= PASS_V) || (rec_i >= PASS_V);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warn_q <= 1'b0;
      pass_q <= 1'b0;
      boff_q <= 1'b0;
    end else begin
      warn_q <= ge_warn;
      pass_q <= ge_pass;
      boff_q <= bus_off_i;
    end
  end

  // edge, not level: a held condition fires once
  assign warn_rise_o = ge_warn & ~warn_q;
  assign pass_rise_o = ge_pass & ~pass_q;
  assign boff_rise_o = bus_off_i & ~boff_q;

  always_comb begin
    if (boff_q)      st = ST_BUSOFF;
    else if (pass_q) st = ST_PASSIVE;
    else if (warn_q) st = ST_WARN;
    else             st = ST_ACTIVE;
  end
  assign state_o = st;

  logic past_valid_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_valid_q <= 1'b0;
    else         past_valid_q <= 1'b1;
  end

  p_boff_state_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_valid_q && $past(bus_off_i) |-> state_o == ST_BUSOFF);

  p_pass_state_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_valid_q && $past((tec_i >= PASS_V) || (rec_i >= PASS_V)) && !$past(bus_off_i)
    |-> state_o == ST_PASSIVE);

  p_active_state_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_valid_q && $past((tec_i < WARN_V) && (rec_i < WARN_V) && !bus_off_i)
    |-> state_o == ST_ACTIVE);
endmodule

// File: rtl/can_w1c_bank.sv
module can_w1c_bank #(
  parameter int              W    = 32,
  parameter logic [W-1:0]    USED = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_data_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, clr;

  assign clr = clr_we_i ? clr_data_i : '0;

  // set has priority over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= ((q_q & ~clr) | set_i) & USED;
  end
  assign q_o = q_q;

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_i & USED) != '0) |=> ((q_o & $past(set_i & USED)) == $past(set_i & USED)));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((q_o & ~clr) != '0) |=> ((q_o & $past(q_o & ~clr)) == $past(q_o & ~clr)));
endmodule

// File: rtl/can_irq_route.sv
module can_irq_route
  import can_fault_pkg::*;
(
  input  logic [REG_W-1:0] flag_i,
  input  logic [REG_W-1:0] gim_i,
  output logic             irq0_o,
  output logic             irq1_o
);
  logic [REG_W-1:0] live;
  logic sys_any, mbx_any;

  assign live    = flag_i & gim_i;
  assign sys_any = |(live & SYS_FLAGS);
  assign mbx_any = |(live & MBOX_FLAGS);

  assign irq0_o = gim_i[GM_LINE0] & (mbx_any | (sys_any & ~gim_i[GM_SYS_L1]));
  assign irq1_o = gim_i[GM_LINE1] & sys_any & gim_i[GM_SYS_L1];
endmodule

// File: rtl/can_fault_irq_ctrl.sv
module can_fault_irq_ctrl
  import can_fault_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  tec_i,
  input  logic [CNT_W-1:0]  rec_i,
  input  logic              bus_off_i,
  input  logic [NCAUSE-1:0] bus_err_i,
  input  logic              mbox_evt_i,
  input  logic [REG_W-1:0]  gim_i,
  input  logic              status_clr_i,
  input  logic              flag_clr_i,
  input  logic [REG_W-1:0]  clr_data_i,
  output logic [REG_W-1:0]  status_o,
  output logic [REG_W-1:0]  flag_o,
  output logic [1:0]        state_o,
  output logic              irq0_o,
  output logic              irq1_o
);
  logic warn_rise, pass_rise, boff_rise;
  logic [REG_W-1:0] status_set, flag_set;

  can_fault_eval #(
    .CNT_W(CNT_W), .WARN_LIM(WARN_LIM), .PASS_LIM(PASS_LIM)
  ) u_eval (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .tec_i(tec_i), .rec_i(rec_i), .bus_off_i(bus_off_i),
    .state_o(state_o),
    .warn_rise_o(warn_rise), .pass_rise_o(pass_rise), .boff_rise_o(boff_rise)
  );

  always_comb begin
    status_set = '0;
    status_set[SB_CAUSE +: NCAUSE] = bus_err_i;
    status_set[SB_WARN] = warn_rise;
    status_set[SB_PASS] = pass_rise;
    status_set[SB_BOFF] = boff_rise;
    flag_set = '0;
    flag_set[FL_WARN] = warn_rise;
    flag_set[FL_PASS] = pass_rise;
    flag_set[FL_BOFF] = boff_rise;
    flag_set[FL_MBOX] = mbox_evt_i;
  end

  can_w1c_bank #(.W(REG_W), .USED(STATUS_USED)) u_status (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(status_set),
    .clr_we_i(status_clr_i), .clr_data_i(clr_data_i), .q_o(status_o)
  );

  can_w1c_bank #(.W(REG_W), .USED(FLAG_USED)) u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(flag_set),
    .clr_we_i(flag_clr_i), .clr_data_i(clr_data_i), .q_o(flag_o)
  );

  can_irq_route u_route (
    .flag_i(flag_o), .gim_i(gim_i), .irq0_o(irq0_o), .irq1_o(irq1_o)
  );

  p_line0_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq0_o |-> gim_i[GM_LINE0] && ((flag_o & gim_i) != '0));

  p_line1_route_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq1_o |-> gim_i[GM_SYS_L1] && ((flag_o & gim_i & SYS_FLAGS) != '0));

  p_flag_status_pair_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o[FL_BOFF]) |-> status_o[SB_BOFF]);
endmodule

// File: tb/tb_can_fault_irq_ctrl.sv
module tb_can_fault_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  tec = '0, rec = '0;
  logic        bus_off = 1'b0;
  logic [5:0]  bus_err = '0;
  logic        mbox_evt = 1'b0;
  logic [31:0] gim = '0;
  logic        status_clr = 1'b0, flag_clr = 1'b0;
  logic [31:0] clr_data = '0;
  logic [31:0] status, flag;
  logic [1:0]  state;
  logic        irq0, irq1;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  can_fault_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .tec_i(tec), .rec_i(rec), .bus_off_i(bus_off),
    .bus_err_i(bus_err), .mbox_evt_i(mbox_evt), .gim_i(gim),
    .status_clr_i(status_clr), .flag_clr_i(flag_clr), .clr_data_i(clr_data),
    .status_o(status), .flag_o(flag), .state_o(state), .irq0_o(irq0), .irq1_o(irq1)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clr_all();
    status_clr = 1; flag_clr = 1; clr_data = '1;
    step();
    status_clr = 0; flag_clr = 0; clr_data = '0;
  endtask

  task automatic t_reset();
    chk(32'(state), 0, "R1 state");
    chk(status, 0, "R1 status");
    chk(flag, 0, "R1 flag");
    chk({30'd0, irq1, irq0}, 0, "R1 irq");
  endtask

  task automatic t_thresholds();
    tec = 95; step();
    chk(32'(state), 0, "R2 active at 95");
    chk(flag, 0, "R3 no flag at 95");
    tec = 96; step();
    chk(32'(state), 1, "R2 warning at 96");
    chk(flag, 32'h100, "R3 warn flag");
    chk(status, 32'h0001_0000, "R3 warn status");
    rec = 127; step();
    chk(32'(state), 1, "R2 warning rec 127");
    rec = 128; step();
    chk(32'(state), 2, "R2 passive rec 128");
    chk(flag, 32'h300, "R4 passive flag");
    chk(status, 32'h0003_0000, "R4 passive status");
    clr_all(); step(); step();
    chk(flag, 0, "R3 no refire while held");
    chk(status, 0, "R4 no refire while held");
    tec = 0; rec = 0; step();
    chk(32'(state), 0, "R2 back to active");
    rec = 200; step();
    chk(flag, 32'h300, "R4 jump sets both");
    chk(32'(state), 2, "R2 passive after jump");
    rec = 0; step(); clr_all();
  endtask

  task automatic t_busoff();
    bus_off = 1; step();
    chk(32'(state), 3, "R5 busoff state");
    chk(flag, 32'h400, "R5 busoff flag");
    chk(status, 32'h0004_0000, "R5 busoff status");
    clr_all(); step();
    chk(flag, 0, "R5 no refire while held");
    tec = 150; step();
    chk(32'(state), 3, "R5 busoff overrides counters");
    bus_off = 0; tec = 0; step(); clr_all();
  endtask

  task automatic t_causes();
    bus_err = 6'b100000; step(); bus_err = 0; step();
    chk(status, 32'h0100_0000, "R6 form cause bit 24");
    bus_err = 6'b000001; step(); bus_err = 0;
    chk(status, 32'h0108_0000, "R6 ack cause bit 19 sticky");
    bus_err = 6'b000100; step(); bus_err = 0;
    chk(status, 32'h0128_0000, "R6 crc cause bit 21");
    status_clr = 1; clr_data = 32'h0100_0000; step(); status_clr = 0;
    chk(status, 32'h0028_0000, "R8 w1c selective");
    flag_clr = 1; clr_data = '1; step(); flag_clr = 0;
    chk(status, 32'h0028_0000, "R8 flag clear leaves status");
    bus_err = 6'b000001; status_clr = 1; clr_data = 32'h0008_0000; step();
    bus_err = 0; status_clr = 0; clr_data = 0;
    chk(status, 32'h0028_0000, "R8 set wins over clear");
    clr_all();
    chk(status, 0, "R8 full clear");
  endtask

  task automatic t_routing();
    gim = 0; mbox_evt = 1; step(); mbox_evt = 0;
    chk(flag, 32'h8000, "R7 mbox flag");
    chk({30'd0, irq1, irq0}, 0, "R9 masked flag latches, no irq");
    gim = 32'h8001; step();
    chk({30'd0, irq1, irq0}, 1, "R9 mbox on line0");
    gim = 32'h8007; step();
    chk({30'd0, irq1, irq0}, 2'b01, "R10 mbox never line1");
    gim = 32'h8006; step();
    chk({30'd0, irq1, irq0}, 0, "R10 mbox not on line1 alone");
    gim = 0; clr_all();
    tec = 100; step();
    chk(flag, 32'h100, "R3 warn flag for routing");
    gim = 32'h0101; step();
    chk({30'd0, irq1, irq0}, 2'b01, "R9 sys on line0");
    gim = 32'h0107; step();
    chk({30'd0, irq1, irq0}, 2'b10, "R10 sys steered to line1");
    gim = 32'h0006; step();
    chk({30'd0, irq1, irq0}, 0, "R10 sys masked");
    gim = 32'h0105; step();
    chk({30'd0, irq1, irq0}, 0, "R10 line1 disabled");
    gim = 32'h0107; flag_clr = 1; clr_data = 32'h100; step(); flag_clr = 0; clr_data = 0;
    chk({30'd0, irq1, irq0}, 0, "R8 clear drops line1");
    tec = 0; gim = 0; step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    step();
    t_reset();
    t_thresholds();
    t_busoff();
    t_causes();
    t_routing();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule